// File: doc/BRIEF.md
# GPIO Level-Mismatch Interrupt Unit

This block turns a bank of general-purpose input lines into interrupt requests. Each line is first passed through a synchronizer. A line is pending whenever its synchronized level differs from a per-line reference-level bit and the line's enable bit is set. No edge is latched. A request lasts exactly as long as the mismatch lasts.

Software services a request by copying the level it just read into the reference bit of that line. The mismatch then disappears, and the next transition of the input, rising or falling, raises a fresh request. A typical service step reads the pending word. It then issues one masked write to the reference register, with the pending lines as the mask and the input level ANDed with the pending lines as the value.

A small register bus gives access to the synchronized input, the reference levels, the enables, the pending word and a core-level source mask. The reference and enable registers take masked writes: the upper half of the write word selects the bits to change, and the lower half carries their new values. A registered interrupt output combines all pending lines, gated by the GPIO source bit of the core mask.

Top module: `gpio_polirq`

## Requirements
- R1: After reset, the reference, enable and core-mask registers read zero, the pending word reads zero and `irq_o` is low.
- R2: A read of offset 0x00 returns the input lines exactly two rising clock edges after a change at `gpio_in`, and not earlier.
- R3: Offset 0x10 returns the pending word, where bit i = (synchronized input i XOR reference bit i) AND enable bit i.
- R4: A write to offset 0x08 updates the enable register as a masked write: bits [31:16] of the write word are the mask and bits [15:0] are the values. Only bits whose mask bit is 1 change, and all others keep their value.
- R5: A write to offset 0x04 updates the reference register with the same masked-write encoding as R4.
- R6: A pending bit stays set for as long as its mismatch holds. Writes to offsets 0x00 and 0x10 change no register and do not clear any pending bit.
- R7: After a reference bit is written equal to the present input level, that line's pending bit clears. The next change of that input, in either direction, sets it again.
- R8: `irq_o` goes high exactly one clock edge after core-mask bit 0 is 1 and at least one line is pending. It goes low one edge after either condition stops holding.
- R9: Offset 0x0C is a plain 32-bit read/write core mask. Bits other than bit 0 do not affect `irq_o`.
- R10: A read of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 16 | Asynchronous input lines |
| bus_en | input | 1 | Bus access strobe, one cycle per write |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The bench acknowledges a line once on a rising input and once on a falling input. A design that latched edges, or that re-armed in only one direction, would miss the second request. It also waits many cycles with a mismatch outstanding and writes to the input and pending offsets. A design with a hidden clear would drop the request there. Masked writes that touch a single bit are checked against neighbouring bits that were set earlier, which catches a design that writes the whole word. `irq_o` is sampled in the cycle right after the core mask is written, to catch an output with zero latency or two cycles of latency.

// File: rtl/gpio_polirq_pkg.sv
package gpio_polirq_pkg;
   localparam int unsigned ADDR_W = 5;

   typedef enum logic [ADDR_W-1:0] {
      OFS_LEVEL   = 5'h00,
      OFS_REFLVL  = 5'h04,
      OFS_ARM     = 5'h08,
      OFS_CORE    = 5'h0C,
      OFS_PENDING = 5'h10
   } reg_ofs_e;

   // bits selected by sel take val, others keep cur
   function automatic logic [31:0] merge_bits(input logic [31:0] cur,
                                              input logic [31:0] sel,
                                              input logic [31:0] val);
      return (cur & ~sel) | (val & sel);
   endfunction
endpackage

// File: rtl/gpio_polirq_sync.sv
module gpio_polirq_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_polirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= '0;
         end else if (s == 0) begin
            chain_q[s] <= async_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_polirq_regs.sv
module gpio_polirq_regs
   import gpio_polirq_pkg::*;
#(
   parameter int unsigned N_LINES = 16,
   parameter int unsigned DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_LINES-1:0] ref_q,
   output logic [N_LINES-1:0] arm_q,
   output logic [DATA_W-1:0] core_q
);
   localparam int unsigned HALF = DATA_W / 2;

   if (N_LINES > HALF) begin : g_bad_pack
      $error("gpio_polirq_regs: N_LINES must fit in half of DATA_W");
   end

   logic [N_LINES-1:0] sel_w, val_w;
   logic               wr_ref, wr_arm, wr_core;
   logic [31:0]        ref_nx, arm_nx;

   assign sel_w   = wdata_i[HALF +: N_LINES];
   assign val_w   = wdata_i[N_LINES-1:0];
   assign wr_ref  = wr_i && (addr_i == OFS_REFLVL);
   assign wr_arm  = wr_i && (addr_i == OFS_ARM);
   assign wr_core = wr_i && (addr_i == OFS_CORE);

   assign ref_nx = merge_bits(32'(ref_q), 32'(sel_w), 32'(val_w));
   assign arm_nx = merge_bits(32'(arm_q), 32'(sel_w), 32'(val_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         arm_q  <= '0;
         core_q <= '0;
      end else begin
         if (wr_ref)  ref_q  <= ref_nx[N_LINES-1:0];
         if (wr_arm)  arm_q  <= arm_nx[N_LINES-1:0];
         if (wr_core) core_q <= wdata_i;
      end
   end

   // R4
   arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_arm |=> $stable(arm_q));
   // R4
   arm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_arm |=> ((arm_q ^ $past(arm_q)) & ~$past(sel_w)) == '0);
   // R5
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ref |=> $stable(ref_q));
   // R5
   ref_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ref |=> ((ref_q ^ $past(ref_q)) & ~$past(sel_w)) == '0);
endmodule

// File: rtl/gpio_polirq_match.sv
module gpio_polirq_match #(
   parameter int unsigned N_LINES = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] level_i,
   input  logic [N_LINES-1:0] ref_i,
   input  logic [N_LINES-1:0] arm_i,
   input  logic               src_en_i,
   output logic [N_LINES-1:0] pending_o,
   output logic               irq_o
);
   logic any_w;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign pending_o[i] = (level_i[i] ^ ref_i[i]) & arm_i[i];
   end

   assign any_w = src_en_i & (|pending_o);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_w;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = any_w;
   end

   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == (IRQ_REG ? $past(src_en_i && pending_o != '0)
                                   : (src_en_i && pending_o != '0))));
endmodule

// File: rtl/gpio_polirq.sv
module gpio_polirq
   import gpio_polirq_pkg::*;
#(
   parameter int unsigned N_LINES       = 16,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned CORE_GPIO_BIT = 0,
   parameter bit          IRQ_REG       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] gpio_in,
   input  logic               bus_en,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);
   localparam int unsigned PAD = DATA_W - N_LINES;

   if (CORE_GPIO_BIT >= DATA_W) begin : g_bad_bit
      $error("gpio_polirq: CORE_GPIO_BIT outside the core mask");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("gpio_polirq: DATA_W must be 32");
   end

   logic [N_LINES-1:0] level_w, ref_w, arm_w, pend_w;
   logic [DATA_W-1:0]  core_w;

   gpio_polirq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(gpio_in), .sync_o(level_w));

   gpio_polirq_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_en & bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .ref_q(ref_w), .arm_q(arm_w), .core_q(core_w));

   gpio_polirq_match #(.N_LINES(N_LINES), .IRQ_REG(IRQ_REG)) match_i (
      .clk(clk), .rst_n(rst_n), .level_i(level_w), .ref_i(ref_w),
      .arm_i(arm_w), .src_en_i(core_w[CORE_GPIO_BIT]),
      .pending_o(pend_w), .irq_o(irq_o));

   always_comb begin
      case (bus_addr)
         OFS_LEVEL:   bus_rdata = {{PAD{1'b0}}, level_w};
         OFS_REFLVL:  bus_rdata = {{PAD{1'b0}}, ref_w};
         OFS_ARM:     bus_rdata = {{PAD{1'b0}}, arm_w};
         OFS_CORE:    bus_rdata = core_w;
         OFS_PENDING: bus_rdata = {{PAD{1'b0}}, pend_w};
         default:     bus_rdata = '0;
      endcase
   end

   // R6
   no_ghost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(level_w) && $stable(ref_w) && $stable(arm_w)) |-> $stable(pend_w));
endmodule

// File: tb/gpio_polirq_tb_top.sv
module gpio_polirq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] gpio_in = '0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   gpio_polirq dut_i (.clk(clk), .rst_n(rst_n), .gpio_in(gpio_in),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic drive_in(input logic [15:0] v);
      @(negedge clk); gpio_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(5'h04, d); check("R1 ref", d, 0);
      rd(5'h08, d); check("R1 arm", d, 0);
      rd(5'h0C, d); check("R1 core", d, 0);
      rd(5'h10, d); check("R1 pending", d, 0);
      check("R1 irq", irq_o, 0);
   endtask

   task automatic t_sync();
      logic [31:0] d;
      @(negedge clk); gpio_in = 16'hA5C3;
      @(negedge clk); rd(5'h00, d); check("R2 one edge", d, 0);
      @(negedge clk); rd(5'h00, d); check("R2 two edges", d, 32'hA5C3);
      drive_in(16'h0000);
   endtask

   task automatic t_masked();
      logic [31:0] d;
      wr(5'h08, 32'h00FF_00F0); rd(5'h08, d); check("R4 first", d, 32'h00F0);
      wr(5'h08, 32'h0101_0001); rd(5'h08, d); check("R4 single bit", d, 32'h00F1);
      wr(5'h08, 32'h0000_FFFF); rd(5'h08, d); check("R4 empty mask", d, 32'h00F1);
      wr(5'h08, 32'h0010_0000); rd(5'h08, d); check("R4 clear one", d, 32'h00E1);
      wr(5'h04, 32'hF00F_AAAA); rd(5'h04, d); check("R5 first", d, 32'hA00A);
      wr(5'h04, 32'h0008_0000); rd(5'h04, d); check("R5 clear one", d, 32'hA002);
      wr(5'h04, 32'hFFFF_0000); rd(5'h04, d); check("R5 all zero", d, 0);
   endtask

   task automatic t_pending();
      logic [31:0] d;
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h04, 32'hFFFF_0F00);
      drive_in(16'h0005);
      rd(5'h10, d); check("R3 mix", d, 32'h0F05);
      wr(5'h08, 32'h0F00_0000);
      rd(5'h10, d); check("R3 disabled", d, 32'h0005);
      wr(5'h04, 32'hFFFF_0000);
      repeat (10) @(negedge clk);
      rd(5'h10, d); check("R6 persists", d, 32'h0005);
      wr(5'h10, 32'hFFFF_FFFF); wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h10, d); check("R6 pend write", d, 32'h0005);
      rd(5'h04, d); check("R6 ref untouched", d, 0);
      rd(5'h08, d); check("R6 arm untouched", d, 32'hF0FF);
      wr(5'h04, 32'h0005_0005);
      rd(5'h10, d); check("R7 ack", d, 0);
      drive_in(16'h0004);
      rd(5'h10, d); check("R7 falling", d, 32'h0001);
      wr(5'h04, 32'h0001_0000);
      rd(5'h10, d); check("R7 ack2", d, 0);
      drive_in(16'h0005);
      rd(5'h10, d); check("R7 rising", d, 32'h0001);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      check("R8 masked off", irq_o, 0);
      wr(5'h0C, 32'hFFFF_FFFE);
      rd(5'h0C, d); check("R9 readback", d, 32'hFFFF_FFFE);
      @(negedge clk); check("R9 other bits", irq_o, 0);
      wr(5'h0C, 32'h0000_0001);
      check("R8 no early", irq_o, 0);
      @(negedge clk); check("R8 one edge", irq_o, 1);
      wr(5'h04, 32'h0001_0001);
      check("R8 hold one edge", irq_o, 1);
      @(negedge clk); check("R8 drop", irq_o, 0);
      rd(5'h14, d); check("R10 unmapped", d, 0);
      rd(5'h1C, d); check("R10 unmapped hi", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sync();
      t_masked();
      t_pending();
      t_irq();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule